// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a two-part logical address, made of a segment selector and an offset within that segment, into a flat physical address. It holds a small table of descriptors. Each descriptor has a base, a length bound, a write-protect attribute and a shareable flag. Software fills the table through a load port that writes one entry per cycle.

On every cycle that a request is presented, the block looks up the selected descriptor and checks for three kinds of failure. A selector past the table length is a range error. An offset at or above the descriptor's length bound is a bounds error. A write to a write-protected descriptor is a protection fault. A request that passes all three checks produces base plus offset. The result is registered, so all outputs appear together one cycle after the request. An illegal access never reports a physical address.

Top module: `seg_xlate`

## Requirements
- R1: After reset, every descriptor is cleared (base 0, length bound 0, no attributes), and `rsp_valid`, `rsp_range_err`, `rsp_bound_err` and `rsp_prot_err` are all 0.
- R2: When `load_en` is high at a clock edge and `load_idx` < NUM_SEG, the entry at `load_idx` takes `load_base`, `load_limit`, `load_wprot` and `load_share`. A request issued in a later cycle sees the new values.
- R3: A request issued at edge N produces `rsp_valid` = 1 after edge N+1. When no request is issued, `rsp_valid` is 0 at the next cycle.
- R4: A request with offset < limit, a selector in range, and either a read or an unprotected entry gives `rsp_paddr` = base + offset with all three error outputs at 0.
- R5: A request with offset >= limit raises `rsp_bound_err`, and `rsp_paddr` is 0.
- R6: A request with selector >= NUM_SEG raises `rsp_range_err` only. It suppresses the bounds and protection checks, and `rsp_paddr` is 0.
- R7: A write (`req_wr` = 1) to an entry whose write-protect bit is set, with the offset in bounds, raises `rsp_prot_err` and not `rsp_bound_err`. `rsp_paddr` is 0. A read of the same entry succeeds.
- R8: `rsp_share` reports the shareable flag of the selected entry for any in-range selector, and is 0 on a range error.
- R9: A load to an index >= NUM_SEG changes no entry.
- R10: At most one of the three error outputs is high in any cycle. The bounds error takes priority over the protection fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_en | input | 1 | Write one descriptor |
| load_idx | input | 4 | Descriptor index to write |
| load_base | input | 16 | Base value |
| load_limit | input | 16 | Length bound |
| load_wprot | input | 1 | Write-protect attribute |
| load_share | input | 1 | Shareable attribute |
| req_valid | input | 1 | Translation request |
| req_seg | input | 4 | Segment selector |
| req_off | input | 16 | Offset within the segment |
| req_wr | input | 1 | 1 = write access, 0 = read |
| rsp_valid | output | 1 | Result valid (one cycle after request) |
| rsp_paddr | output | 17 | Physical address, 0 on any error |
| rsp_range_err | output | 1 | Selector beyond table |
| rsp_bound_err | output | 1 | Offset at or above the length bound |
| rsp_prot_err | output | 1 | Write to a protected segment |
| rsp_share | output | 1 | Shareable flag of the selected entry |

## Verification
Several properties are checked by assertions on every cycle: the one-cycle response timing, that the error outputs are mutually exclusive, that any error forces a zero physical address, and that a range error blocks the other checks. Some behaviours only the bench scenarios can show. These are the actual sums produced from a loaded five-entry table and the exact limit boundary (limit-1 passes, limit fails). They also include the fault on a write to a protected entry alongside a successful read of it, and that a load to an out-of-range index leaves the table unchanged.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
    parameter int SEG_W  = 4;
    parameter int ADDR_W = 16;
    localparam int PA_W  = ADDR_W + 1;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] limit;
        logic              wprot;
        logic              share;
    } seg_desc_t;

    typedef struct packed {
        logic            valid;
        logic [PA_W-1:0] paddr;
        logic            range_err;
        logic            bound_err;
        logic            prot_err;
        logic            share;
    } xlate_rsp_t;
endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
    import seg_xlate_pkg::*;
#(
    parameter int NUM_SEG = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SEG_W-1:0]     wr_idx,
    input  seg_desc_t            wr_desc,
    input  logic [SEG_W-1:0]     rd_idx,
    output seg_desc_t            rd_desc,
    output logic                 rd_in_range
);
    seg_desc_t tbl_q [NUM_SEG];
    seg_desc_t tbl_d [NUM_SEG];

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_entry
        always_comb begin
            tbl_d[g] = tbl_q[g];
            if (wr_en && (32'(wr_idx) == g))
                tbl_d[g] = wr_desc;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tbl_q[g] <= '0;
            else        tbl_q[g] <= tbl_d[g];
        end
    end

    always_comb begin
        rd_in_range = 32'(rd_idx) < NUM_SEG;
        rd_desc     = '0;
        for (int i = 0; i < NUM_SEG; i++)
            if (32'(rd_idx) == i) rd_desc = tbl_q[i];
    end
endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlate_pkg::*;
(
    input  logic              req_valid,
    input  logic              in_range,
    input  seg_desc_t         desc,
    input  logic [ADDR_W-1:0] off,
    input  logic              wr,
    output xlate_rsp_t        rsp
);
    logic in_bound;

    always_comb begin
        in_bound      = off < desc.limit;
        rsp           = '0;
        rsp.valid     = req_valid;
        if (req_valid) begin
            if (!in_range) begin
                rsp.range_err = 1'b1;
            end else begin
                rsp.share = desc.share;
                if (!in_bound)             rsp.bound_err = 1'b1;
                else if (wr && desc.wprot) rsp.prot_err  = 1'b1;
                else rsp.paddr = PA_W'(desc.base) + PA_W'(off);
            end
        end
    end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int NUM_SEG = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [SEG_W-1:0]  load_idx,
    input  logic [ADDR_W-1:0] load_base,
    input  logic [ADDR_W-1:0] load_limit,
    input  logic              load_wprot,
    input  logic              load_share,
    input  logic              req_valid,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [ADDR_W-1:0] req_off,
    input  logic              req_wr,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_range_err,
    output logic              rsp_bound_err,
    output logic              rsp_prot_err,
    output logic              rsp_share
);
    seg_desc_t  wr_desc, rd_desc;
    logic       in_range;
    xlate_rsp_t rsp_d, rsp_q;

    assign wr_desc = '{base: load_base, limit: load_limit,
                       wprot: load_wprot, share: load_share};

    seg_desc_table #(.NUM_SEG(NUM_SEG)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (load_en),
        .wr_idx     (load_idx),
        .wr_desc    (wr_desc),
        .rd_idx     (req_seg),
        .rd_desc    (rd_desc),
        .rd_in_range(in_range)
    );

    seg_check u_check (
        .req_valid(req_valid),
        .in_range (in_range),
        .desc     (rd_desc),
        .off      (req_off),
        .wr       (req_wr),
        .rsp      (rsp_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid     = rsp_q.valid;
    assign rsp_paddr     = rsp_q.paddr;
    assign rsp_range_err = rsp_q.range_err;
    assign rsp_bound_err = rsp_q.bound_err;
    assign rsp_prot_err  = rsp_q.prot_err;
    assign rsp_share     = rsp_q.share;

    // R3: response one cycle after request
    a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R10: errors mutually exclusive
    a_r10_onehot_err: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_range_err, rsp_bound_err, rsp_prot_err}));
    // R5/R7: any error zeroes the address
    a_r5_err_zero_pa: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_range_err || rsp_bound_err || rsp_prot_err) |-> rsp_paddr == '0);
    // R6: out-of-range selector reports range error only
    a_r6_range: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && 32'(req_seg) >= NUM_SEG) |=> (rsp_range_err && !rsp_share));
    // R7: reads never raise a protection fault
    a_r7_read_no_prot: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_wr) |=> !rsp_prot_err);
endmodule

// File: tb/test_seg_xlate.sv
module test_seg_xlate;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        load_en = 0;
    logic [3:0]  load_idx = 0;
    logic [15:0] load_base = 0, load_limit = 0;
    logic        load_wprot = 0, load_share = 0;
    logic        req_valid = 0;
    logic [3:0]  req_seg = 0;
    logic [15:0] req_off = 0;
    logic        req_wr = 0;
    logic        rsp_valid;
    logic [16:0] rsp_paddr;
    logic        rsp_range_err, rsp_bound_err, rsp_prot_err, rsp_share;

    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    seg_xlate i_seg_xlate (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load(int idx, int base, int lim, bit wp, bit sh);
        @(negedge clk);
        load_en = 1; load_idx = 4'(idx); load_base = 16'(base);
        load_limit = 16'(lim); load_wprot = wp; load_share = sh;
        @(negedge clk);
        load_en = 0;
    endtask

    // issue one request, sample result at next negedge
    task automatic xl(int seg, int off, bit wr);
        @(negedge clk);
        req_valid = 1; req_seg = 4'(seg); req_off = 16'(off); req_wr = wr;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic expect_ok(string req, int pa, bit sh);
        chk({req, " valid"}, 32'(rsp_valid), 1);
        chk({req, " paddr"}, 32'(rsp_paddr), 32'(pa));
        chk({req, " errs"}, {29'd0, rsp_range_err, rsp_bound_err, rsp_prot_err}, 0);
        chk({req, " share"}, 32'(rsp_share), 32'(sh));
    endtask

    task automatic t_reset();
        chk("R1 valid", 32'(rsp_valid), 0);
        chk("R1 errs", {29'd0, rsp_range_err, rsp_bound_err, rsp_prot_err}, 0);
        xl(0, 0, 0);   // cleared entry: limit 0 -> bound error
        chk("R1 cleared entry bound", 32'(rsp_bound_err), 1);
    endtask

    task automatic t_table();
        load(0, 1400, 1000, 1, 1);
        load(1, 6300, 400, 0, 0);
        load(2, 4300, 400, 0, 1);
        load(3, 3200, 1100, 0, 0);
        load(4, 4700, 1000, 0, 0);
        xl(0, 0, 0);    expect_ok("R2 R4 seg0", 1400, 1);
        xl(1, 53, 1);   expect_ok("R4 seg1", 6353, 0);
        xl(2, 399, 0);  expect_ok("R4 seg2 limit-1", 4699, 1);
        xl(3, 852, 1);  expect_ok("R4 seg3", 4052, 0);
        xl(4, 999, 0);  expect_ok("R8 seg4", 5699, 0);
        xl(2, 400, 0);
        chk("R5 bound at limit", 32'(rsp_bound_err), 1);
        chk("R5 paddr zero", 32'(rsp_paddr), 0);
        chk("R8 share on bound err", 32'(rsp_share), 1);
        xl(1, 1222, 0);
        chk("R5 bound beyond", 32'(rsp_bound_err), 1);
    endtask

    task automatic t_range();
        xl(5, 0, 1);
        chk("R6 range err", 32'(rsp_range_err), 1);
        chk("R6 others clear", {30'd0, rsp_bound_err, rsp_prot_err}, 0);
        chk("R6 paddr zero", 32'(rsp_paddr), 0);
        chk("R8 share zero on range", 32'(rsp_share), 0);
        xl(15, 9, 0);
        chk("R6 range err max sel", 32'(rsp_range_err), 1);
    endtask

    task automatic t_prot();
        xl(0, 10, 1);
        chk("R7 prot fault", 32'(rsp_prot_err), 1);
        chk("R7 no bound", 32'(rsp_bound_err), 0);
        chk("R7 paddr zero", 32'(rsp_paddr), 0);
        xl(0, 10, 0);   expect_ok("R7 read ok", 1410, 1);
        xl(0, 1000, 1);
        chk("R10 bound over prot", 32'(rsp_bound_err), 1);
        chk("R10 prot suppressed", 32'(rsp_prot_err), 0);
    endtask

    task automatic t_badload();
        load(5, 100, 100, 0, 0);
        load(12, 100, 100, 0, 0);
        xl(4, 10, 0);   expect_ok("R9 seg4 unchanged", 4710, 0);
        xl(0, 10, 1);   chk("R9 seg0 still protected", 32'(rsp_prot_err), 1);
        xl(5, 10, 0);   chk("R9 still out of range", 32'(rsp_range_err), 1);
    endtask

    task automatic t_idle();
        xl(3, 1, 0);
        @(negedge clk);
        chk("R3 idle no valid", 32'(rsp_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_pre: begin
            chk("R1 reset valid low", 32'(rsp_valid), 0);
        end
        rst_n = 1;
        t_reset();
        t_table();
        t_range();
        t_prot();
        t_badload();
        t_idle();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #100000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule